// File: doc/BRIEF.md
# Supervisory watchdog and reset timer

This block supervises a processor. It generates the processor reset pulse and watches a kick line that software must toggle regularly. All timing is counted in ticks of a timebase enable (`tick_en`), which stands in for the supervisor oscillator. When the processor stops toggling the kick line for a full timeout period, the block issues a fixed-length reset pulse and latches a watchdog status flag low.

After every reset, whether from power-up, a timeout or a low supply, the first timeout is an extended one. This gives firmware time to initialise before it starts kicking. A short period can be selected, but it only applies after software has toggled the kick line at least once since the last reset. Two modes are supported. In external-count mode the periods are 4096 ticks first and 1024 ticks afterwards. In internal-timebase mode a select picks either a fixed 16384-tick period (1.6 s at 10.24 kHz) or a 1024-tick period (100 ms), and the 1024-tick period is only used once software has kicked. The reset pulse lasts 512 or 2048 ticks.

A supply-low indication forces reset and holds it. The pulse length is counted only from the moment the supply recovers. While the supply is low, the status flag is forced high.

Top module: `supv_wdog`

## Requirements
- R1: While `rst` is high, `rst_out`=1, `rst_out_n`=0 and `wdo_out`=1. After `rst` falls, a reset pulse of the selected length runs.
- R2: A reset pulse lasts PULSE_SHORT_TICKS ticks when `pulse_long`=0 and PULSE_LONG_TICKS ticks when `pulse_long`=1.
- R3: With `ext_mode`=1, the first timeout after reset is FIRST_EXT_TICKS ticks if no kick has been seen.
- R4: With `ext_mode`=1, after a kick edge the period is NORM_TICKS ticks, counted from that edge.
- R5: With `ext_mode`=0 and `short_sel`=0, the period is LONG_INT_TICKS ticks both before and after kicks.
- R6: With `ext_mode`=0 and `short_sel`=1, the period is LONG_INT_TICKS ticks until the first kick edge after reset, and NORM_TICKS ticks after it.
- R7: A rising or a falling transition of `kick_in` is a kick. It passes through a two-flop synchroniser and clears the watchdog count on the third clock edge after the input changes.
- R8: A timeout raises `rst_out` and drives `wdo_out` low on the same edge.
- R9: `wdo_out` stays low after a timeout, through the reset pulse, until the next kick edge sets it to 1.
- R10: While `supply_low`=1, `rst_out`=1 and `wdo_out`=1 are held. After it clears, the pulse runs its full selected length in ticks.
- R11: While reset is asserted, the watchdog count is held at zero and the extended first period is re-armed. Kicks during the pulse do not arm the short period.
- R12: `rst_out_n` is always the exact complement of `rst_out`.
- R13: Clock cycles with `tick_en`=0 advance neither the timeout count nor the pulse count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| tick_en | input | 1 | Timebase tick enable, one count per high cycle |
| kick_in | input | 1 | Asynchronous watchdog kick line, either edge counts |
| ext_mode | input | 1 | 1 = external-count periods, 0 = internal-timebase periods |
| short_sel | input | 1 | Internal mode: 1 = short period after first kick, 0 = long period always |
| pulse_long | input | 1 | 0 = short reset pulse, 1 = long reset pulse |
| supply_low | input | 1 | Supply-low indication, holds reset while high |
| rst_out | output | 1 | Active-high reset |
| rst_out_n | output | 1 | Active-low reset |
| wdo_out | output | 1 | Watchdog status, low after a timeout |

## Verification
The bench measures every reset pulse and every watchdog period in ticks, with random tick density. A design that counted clock cycles instead of ticks, or that was off by one at the terminal count, gives wrong lengths. Kicks are placed both inside the reset pulse and early in the following low phase. A design that let a kick arm the short period during reset, or that never re-armed the extended first period, times out too early. Status-flag checks land on the exact cycles on either side of the synchronised kick edge. The supply-low test is run while the flag is low, so a design that ignored the supply override, or restarted the pulse count too early, is caught.

// File: rtl/supv_pkg.sv
package supv_pkg;

    // Which timeout period the watchdog counter is comparing against.
    typedef enum logic [1:0] {
        PER_FIRST_EXT = 2'd0,
        PER_NORMAL    = 2'd1,
        PER_LONG_INT  = 2'd2
    } per_e;

    // Reset pulse length variant.
    typedef enum logic {
        PLEN_SHORT = 1'b0,
        PLEN_LONG  = 1'b1
    } plen_e;

    // Output bundle of the block.
    typedef struct packed {
        logic rst_hi;
        logic rst_lo;
        logic wdo;
    } sup_out_t;

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Period in force for the given mode, select and first-period flag.
    function automatic per_e pick_period(input logic ext_mode,
                                         input logic short_sel,
                                         input logic first_arm);
        if (ext_mode)
            return first_arm ? PER_FIRST_EXT : PER_NORMAL;
        if (short_sel && !first_arm)
            return PER_NORMAL;
        return PER_LONG_INT;
    endfunction

endpackage

// File: rtl/supv_kick_sync.sv
module supv_kick_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic edge_o
);
    // Stages 0..STAGES-1 synchronise; stage STAGES holds the previous value.
    logic [STAGES:0] chain;

    generate
        for (genvar i = 0; i <= STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    // Either polarity of transition is a kick.
    assign edge_o = chain[STAGES-1] ^ chain[STAGES];

endmodule

// File: rtl/supv_wd_timer.sv
module supv_wd_timer
    import supv_pkg::*;
#(
    parameter int NORM_TICKS      = 1024,
    parameter int FIRST_EXT_TICKS = 4096,
    parameter int LONG_INT_TICKS  = 16384,
    parameter int CNT_W           = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             hold,
    input  logic             kick,
    input  logic             ext_mode,
    input  logic             short_sel,
    output logic             timeout,
    output logic [CNT_W-1:0] cnt,
    output logic             first_arm
);
    localparam logic [CNT_W-1:0] LIM_NORM  = CNT_W'(NORM_TICKS - 1);
    localparam logic [CNT_W-1:0] LIM_FIRST = CNT_W'(FIRST_EXT_TICKS - 1);
    localparam logic [CNT_W-1:0] LIM_LONG  = CNT_W'(LONG_INT_TICKS - 1);

    per_e             per;
    logic [CNT_W-1:0] lim_m1;

    always_comb begin
        per = pick_period(ext_mode, short_sel, first_arm);
        unique case (per)
            PER_FIRST_EXT: lim_m1 = LIM_FIRST;
            PER_NORMAL:    lim_m1 = LIM_NORM;
            default:       lim_m1 = LIM_LONG;
        endcase
    end

    // Terminal tick. A kick on the same edge wins. The >= comparison keeps a
    // mid-count switch to a shorter period from wrapping.
    assign timeout = !rst && !hold && !kick && tick_en && (cnt >= lim_m1);

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            cnt       <= '0;
            first_arm <= 1'b1;
        end else if (kick) begin
            cnt       <= '0;
            first_arm <= 1'b0;
        end else if (tick_en) begin
            if (cnt >= lim_m1) cnt <= '0;
            else               cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/supv_rst_pulse.sv
module supv_rst_pulse
    import supv_pkg::*;
#(
    parameter int PULSE_SHORT_TICKS = 512,
    parameter int PULSE_LONG_TICKS  = 2048,
    parameter int PW                = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_en,
    input  logic          start,
    input  logic          supply_low,
    input  plen_e         len_sel,
    output logic          active,
    output logic [PW-1:0] cnt
);
    localparam logic [PW-1:0] END_SHORT = PW'(PULSE_SHORT_TICKS - 1);
    localparam logic [PW-1:0] END_LONG  = PW'(PULSE_LONG_TICKS - 1);

    logic [PW-1:0] last;
    assign last = (len_sel == PLEN_LONG) ? END_LONG : END_SHORT;

    always_ff @(posedge clk) begin
        if (rst || supply_low || start) begin
            // Power-up, low supply and timeout all restart the pulse.
            active <= 1'b1;
            cnt    <= '0;
        end else if (active && tick_en) begin
            if (cnt >= last) begin
                active <= 1'b0;
                cnt    <= '0;
            end else begin
                cnt    <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/supv_wdog.sv
module supv_wdog
    import supv_pkg::*;
#(
    parameter int NORM_TICKS        = 1024,
    parameter int FIRST_EXT_TICKS   = 4096,
    parameter int LONG_INT_TICKS    = 16384,
    parameter int PULSE_SHORT_TICKS = 512,
    parameter int PULSE_LONG_TICKS  = 2048,
    parameter int SYNC_STAGES       = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_en,
    input  logic kick_in,
    input  logic ext_mode,
    input  logic short_sel,
    input  logic pulse_long,
    input  logic supply_low,
    output logic rst_out,
    output logic rst_out_n,
    output logic wdo_out
);
    localparam int MAX_PER = int'(umax(umax(NORM_TICKS, FIRST_EXT_TICKS), LONG_INT_TICKS));
    localparam int CNT_W   = $clog2(MAX_PER + 1);
    localparam int PW      = $clog2(int'(umax(PULSE_SHORT_TICKS, PULSE_LONG_TICKS)) + 1);

    logic             kick_edge;
    logic             timeout;
    logic             rst_active;
    logic             first_arm;
    logic [CNT_W-1:0] wd_cnt;
    logic [PW-1:0]    pulse_cnt;
    logic             wdo_q;
    sup_out_t         outs;

    supv_kick_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst    (rst),
        .din    (kick_in),
        .edge_o (kick_edge)
    );

    supv_wd_timer #(
        .NORM_TICKS      (NORM_TICKS),
        .FIRST_EXT_TICKS (FIRST_EXT_TICKS),
        .LONG_INT_TICKS  (LONG_INT_TICKS),
        .CNT_W           (CNT_W)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .hold      (rst_active),
        .kick      (kick_edge),
        .ext_mode  (ext_mode),
        .short_sel (short_sel),
        .timeout   (timeout),
        .cnt       (wd_cnt),
        .first_arm (first_arm)
    );

    supv_rst_pulse #(
        .PULSE_SHORT_TICKS (PULSE_SHORT_TICKS),
        .PULSE_LONG_TICKS  (PULSE_LONG_TICKS),
        .PW                (PW)
    ) u_pulse (
        .clk        (clk),
        .rst        (rst),
        .tick_en    (tick_en),
        .start      (timeout),
        .supply_low (supply_low),
        .len_sel    (plen_e'(pulse_long)),
        .active     (rst_active),
        .cnt        (pulse_cnt)
    );

    // Status latch: cleared by a timeout, set by a kick edge, forced high
    // by a low supply.
    always_ff @(posedge clk) begin
        if (rst || supply_low || kick_edge) wdo_q <= 1'b1;
        else if (timeout)                   wdo_q <= 1'b0;
    end

    always_comb begin
        outs.rst_hi = rst_active;
        outs.rst_lo = ~rst_active;
        outs.wdo    = wdo_q;
    end

    assign rst_out   = outs.rst_hi;
    assign rst_out_n = outs.rst_lo;
    assign wdo_out   = outs.wdo;

endmodule

// File: rtl/supv_wdog_chk.sv
module supv_wdog_chk #(
    parameter int CNT_W = 15,
    parameter int PW    = 12,
    parameter int PS    = 512,
    parameter int PL    = 2048
) (
    input logic             clk,
    input logic             rst,
    input logic             tick_en,
    input logic             supply_low,
    input logic             pulse_long,
    input logic             rst_out,
    input logic             rst_out_n,
    input logic             wdo_out,
    input logic             kick_edge,
    input logic             timeout,
    input logic             rst_active,
    input logic             first_arm,
    input logic [CNT_W-1:0] wd_cnt,
    input logic [PW-1:0]    pulse_cnt
);
    localparam logic [PW-1:0] LAST_S = PW'(PS - 1);
    localparam logic [PW-1:0] LAST_L = PW'(PL - 1);

    a_r12_complement: assert property (@(posedge clk) disable iff (rst)
        rst_out_n == ~rst_out);

    a_r10_supply_forces: assert property (@(posedge clk) disable iff (rst)
        supply_low |=> (rst_out && wdo_out));

    a_r8_timeout_starts: assert property (@(posedge clk) disable iff (rst)
        (timeout && !supply_low) |=> (rst_out && !wdo_out));

    a_r11_hold_clear: assert property (@(posedge clk) disable iff (rst)
        rst_active |=> ((wd_cnt == '0) && first_arm));

    a_r9_wdo_rise_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(wdo_out) |-> ($past(kick_edge) || $past(supply_low)));

    a_r7_kick_clears: assert property (@(posedge clk) disable iff (rst)
        (kick_edge && !rst_active) |=> ((wd_cnt == '0) && !first_arm));

    a_r2_pulse_ends: assert property (@(posedge clk) disable iff (rst)
        (rst_active && !supply_low && tick_en &&
         pulse_cnt == (pulse_long ? LAST_L : LAST_S)) |=> !rst_out);

    a_r13_no_tick_hold: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && rst_active && !supply_low) |=> $stable(pulse_cnt));

endmodule

bind supv_wdog supv_wdog_chk #(
    .CNT_W (CNT_W),
    .PW    (PW),
    .PS    (PULSE_SHORT_TICKS),
    .PL    (PULSE_LONG_TICKS)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick_en    (tick_en),
    .supply_low (supply_low),
    .pulse_long (pulse_long),
    .rst_out    (rst_out),
    .rst_out_n  (rst_out_n),
    .wdo_out    (wdo_out),
    .kick_edge  (kick_edge),
    .timeout    (timeout),
    .rst_active (rst_active),
    .first_arm  (first_arm),
    .wd_cnt     (wd_cnt),
    .pulse_cnt  (pulse_cnt)
);

// File: tb/test_supv_wdog.sv
module test_supv_wdog;
    localparam int NT  = 20;
    localparam int FE  = 50;
    localparam int LI  = 90;
    localparam int PSH = 6;
    localparam int PLO = 15;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_en = 1'b0, kick_in = 1'b0, ext_mode = 1'b1, short_sel = 1'b0;
    logic pulse_long = 1'b0, supply_low = 1'b0;
    logic rst_out, rst_out_n, wdo_out;

    int checks = 0, errors = 0, cyc = 0;
    logic wdo_j2, wdo_j3;

    always #4 clk = ~clk;

    supv_wdog #(
        .NORM_TICKS (NT), .FIRST_EXT_TICKS (FE), .LONG_INT_TICKS (LI),
        .PULSE_SHORT_TICKS (PSH), .PULSE_LONG_TICKS (PLO), .SYNC_STAGES (2)
    ) i_supv_wdog (
        .clk (clk), .rst (rst), .tick_en (tick_en), .kick_in (kick_in),
        .ext_mode (ext_mode), .short_sel (short_sel), .pulse_long (pulse_long),
        .supply_low (supply_low), .rst_out (rst_out), .rst_out_n (rst_out_n),
        .wdo_out (wdo_out)
    );

    function automatic int exp_lim(input logic ext, input logic ss, input logic kicked);
        if (ext) return kicked ? NT : FE;
        if (ss && kicked) return NT;
        return LI;
    endfunction

    function automatic int exp_pulse(input logic lng);
        return lng ? PLO : PSH;
    endfunction

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Called at a negedge where rst_out == level. Returns at the first negedge
    // where rst_out differs. Ticks in the low phase are counted only from the
    // edge after the kick has taken effect.
    task automatic run_phase(input logic level, input int kick_at, input int pct,
                             output int ticks);
        int n = 0;
        ticks = 0;
        while (rst_out === level && n < 20000) begin
            if (n == kick_at) kick_in = ~kick_in;
            if (kick_at >= 0 && n == kick_at + 2) wdo_j2 = wdo_out;
            if (kick_at >= 0 && n == kick_at + 3) wdo_j3 = wdo_out;
            tick_en = ($urandom_range(99) < pct);
            if (tick_en && (level || kick_at < 0 || n >= kick_at + 3)) ticks++;
            n++;
            @(negedge clk);
        end
        tick_en = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int t;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1 reset state
        check(rst_out === 1'b1, "R1 rst_out in reset", int'(rst_out), 1);
        check(rst_out_n === 1'b0, "R1 rst_out_n in reset", int'(rst_out_n), 0);
        check(wdo_out === 1'b1, "R1 wdo_out in reset", int'(wdo_out), 1);
        rst = 1'b0;
        run_phase(1'b1, -1, 60, t);
        check(t == PSH, "R1 R2 short pulse after reset", t, PSH);
        // R3 extended first period, random tick density (R13)
        pulse_long = 1'b1;
        run_phase(1'b0, -1, 50, t);
        check(t == FE, "R3 R13 first ext period", t, FE);
        check(rst_out === 1'b1 && wdo_out === 1'b0, "R8 timeout raises reset, wdo low",
              int'({rst_out, wdo_out}), 2);
        check(rst_out_n === ~rst_out, "R12 complement", int'(rst_out_n), int'(~rst_out));
        run_phase(1'b1, -1, 70, t);
        check(t == PLO, "R2 long pulse", t, PLO);
        check(wdo_out === 1'b0, "R9 wdo low after pulse", int'(wdo_out), 0);
        // R10 supply-low while wdo low
        repeat (10) begin tick_en = 1'b1; @(negedge clk); end
        check(wdo_out === 1'b0 && rst_out === 1'b0, "R9 wdo still low before kick",
              int'(wdo_out), 0);
        supply_low = 1'b1;
        repeat (2) @(negedge clk);
        check(rst_out === 1'b1 && wdo_out === 1'b1, "R10 supply low forces",
              int'({rst_out, wdo_out}), 3);
        repeat (8) begin tick_en = 1'b1; @(negedge clk); end
        check(rst_out === 1'b1 && rst_out_n === 1'b0, "R10 R12 held in supply low",
              int'({rst_out, rst_out_n}), 2);
        supply_low = 1'b0;
        run_phase(1'b1, -1, 80, t);
        check(t == PLO, "R10 full pulse after supply recovers", t, PLO);
        // R4 R7 short period after kick in ext mode
        run_phase(1'b0, 5, 60, t);
        check(t == NT, "R4 R7 normal period after kick", t, NT);
        // R9: pre-timeout flag was 1 here (supply forced it), so use the next one
        run_phase(1'b1, -1, 100, t);
        check(wdo_out === 1'b0, "R8 wdo low after timeout", int'(wdo_out), 0);
        run_phase(1'b0, 4, 100, t);
        check(wdo_j2 === 1'b0, "R9 wdo low before kick takes effect", int'(wdo_j2), 0);
        check(wdo_j3 === 1'b1, "R7 R9 wdo set on kick edge", int'(wdo_j3), 1);
        check(t == NT, "R4 normal period", t, NT);
        // R11 kick during pulse does not arm short period
        ext_mode = 1'b0; short_sel = 1'b1;
        run_phase(1'b1, 0, 100, t);
        check(t == PLO, "R2 pulse with kick inside", t, PLO);
        run_phase(1'b0, -1, 70, t);
        check(t == LI, "R6 R11 long first internal period", t, LI);
        run_phase(1'b1, -1, 70, t);
        run_phase(1'b0, 3, 70, t);
        check(t == NT, "R6 short period after kick", t, NT);
        short_sel = 1'b0;
        run_phase(1'b1, -1, 70, t);
        run_phase(1'b0, 4, 70, t);
        check(t == LI, "R5 long period after kick", t, LI);
        // Random mix
        for (int i = 0; i < 40; i++) begin
            logic e = 1'($urandom_range(1));
            logic s = 1'($urandom_range(1));
            logic p = 1'($urandom_range(1));
            int   k = ($urandom_range(2) == 0) ? -1 : int'($urandom_range(10));
            int   d = 40 + int'($urandom_range(60));
            ext_mode = e; short_sel = s; pulse_long = p;
            run_phase(1'b1, -1, d, t);
            check(t == exp_pulse(p), "R2 random pulse", t, exp_pulse(p));
            run_phase(1'b0, k, d, t);
            check(t == exp_lim(e, s, k >= 0), "R3 R4 R5 R6 random period", t,
                  exp_lim(e, s, k >= 0));
            check(rst_out_n === ~rst_out, "R12 random complement", int'(rst_out_n),
                  int'(~rst_out));
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule